// File: doc/BRIEF.md
# Physical Region Split Guard

This block guards a two-way split of physical memory. A single page-aligned boundary register divides the address space. Everything at or above the boundary belongs to the privileged region, and everything below it to the unprivileged region. Two kinds of traffic pass through the same comparison against the boundary: translations about to be installed in a core's TLB after a miss, or real-mode accesses that bypass translation, and DMA requests from devices.

A privileged core may reach both regions. An unprivileged core is refused any fill or real-mode access whose physical address lands in the privileged region. A device that is not authorized cannot write into the privileged region. Device reads are never filtered. TLB hits never pass through the block, so they add no latency. Each request gets a registered verdict exactly one cycle later. The verdict carries:
- an allow flag
- a fault code
- the checked address
- a TLB write enable
- a DMA forward enable
- a one-cycle fault pulse for refused core requests

Refused device writes are dropped, and they raise a sticky error flag. Only a privileged requester on the configuration port can move the boundary or clear that flag.

Top module: `pa_split_guard`

## Requirements
- R1: After synchronous reset the boundary output equals the page-aligned reset value, and `dma_err_o`, `dec_valid_o`, `tlb_we_o`, `dma_fwd_o` and `fault_o` are all 0.
- R2: An address is privileged when it is greater than or equal to the boundary. An unprivileged fill at exactly the boundary is refused, and one at boundary minus one is allowed with `tlb_we_o`=1.
- R3: An unprivileged core (class 1) requesting a fill (type 0) or a real-mode access (type 1) in the privileged region is refused with code 1 (fill) or code 2 (real). `fault_o` is 1 for that single decision cycle, `dec_addr_o` carries the address, and `tlb_we_o` stays 0.
- R4: A privileged core (class 0) is allowed in both regions. A fill gives `tlb_we_o`=1, and a real-mode access gives `tlb_we_o`=0.
- R5: The verdict for a request presented with `req_valid_i`=1 appears exactly one clock later with `dec_valid_o`=1. After a cycle without a request, `dec_valid_o`, `tlb_we_o`, `dma_fwd_o` and `fault_o` are 0.
- R6: A device (class 2) DMA write (type 2) with `req_auth_i`=0 to the privileged region is refused with code 3, `dma_fwd_o`=0, and sets `dma_err_o` from the next cycle. A device DMA write that is authorized or below the boundary, and every device DMA read (type 3), is forwarded with `dma_fwd_o`=1.
- R7: `dma_err_o` stays set until a configuration write with `cfg_priv_i`=1, `cfg_op_i`=1 and `cfg_wdata_i[0]`=1. A new refusal in the clearing cycle wins over the clear.
- R8: A configuration write with `cfg_priv_i`=1 and `cfg_op_i`=0 loads the boundary from `cfg_wdata_i`, with the low PAGE_BITS bits forced to 0, visible on `bound_o` the next cycle. Configuration writes with `cfg_priv_i`=0 change neither `bound_o` nor `dma_err_o`.
- R9: A mismatched request is refused with code 4. Mismatched means a core class with a DMA type, a device with a fill or real-mode type, or the reserved class 3. A refusal from a non-device class pulses `fault_o`, and a refusal from a device sets `dma_err_o`.
- R10: A request presented in the same cycle as a boundary write is judged against the boundary held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 1 | Configuration writer is privileged |
| cfg_op_i | input | 1 | 0: load boundary, 1: clear error (write-one on bit 0) |
| cfg_wdata_i | input | ADDR_W | Configuration write data |
| bound_o | output | ADDR_W | Current boundary |
| dma_err_o | output | 1 | Sticky refused-DMA flag |
| req_valid_i | input | 1 | Request present |
| req_class_i | input | 2 | 0 privileged core, 1 unprivileged core, 2 device, 3 reserved |
| req_type_i | input | 2 | 0 fill, 1 real-mode, 2 DMA write, 3 DMA read |
| req_auth_i | input | 1 | Device is authorized |
| req_addr_i | input | ADDR_W | Physical address to check |
| dec_valid_o | output | 1 | Verdict present |
| dec_allow_o | output | 1 | Request allowed |
| dec_code_o | output | 3 | 0 none, 1 fill refused, 2 real refused, 3 DMA blocked, 4 bad request |
| dec_addr_o | output | ADDR_W | Address that was judged |
| tlb_we_o | output | 1 | Install the translation |
| dma_fwd_o | output | 1 | Forward the DMA request |
| fault_o | output | 1 | One-cycle fault for a refused core request |

## Verification
The bench builds the block with ADDR_W=20, PAGE_BITS=12 and a reset boundary of 0x80000. With these values, addresses at the boundary, one below it, and at the top of the space can be hit directly, and random addresses land near the boundary often. Random configuration writes move the boundary across the whole space, including zero, where every address is privileged. The mix also includes writes that carry low-order bits, which must be dropped, and boundary writes that coincide with requests. Sticky-flag set and clear collisions and unprivileged configuration attempts are driven as directed cases.

// File: rtl/pa_split_pkg.sv
package pa_split_pkg;

    typedef enum logic [1:0] {
        CLS_PRIV_CORE   = 2'd0,
        CLS_UNPRIV_CORE = 2'd1,
        CLS_DEVICE      = 2'd2,
        CLS_RSVD        = 2'd3
    } req_class_e;

    typedef enum logic [1:0] {
        KIND_FILL   = 2'd0,
        KIND_REAL   = 2'd1,
        KIND_DMA_WR = 2'd2,
        KIND_DMA_RD = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_FILL_DENY = 3'd1,
        FC_REAL_DENY = 3'd2,
        FC_DMA_BLOCK = 3'd3,
        FC_BAD_REQ   = 3'd4
    } fault_code_e;

    typedef enum logic {
        CFG_OP_BOUND  = 1'b0,
        CFG_OP_ERRCLR = 1'b1
    } cfg_op_e;

    typedef struct packed {
        logic        allow;
        fault_code_e code;
        logic        tlb_we;
        logic        dma_fwd;
        logic        fault;
        logic        err_set;
    } verdict_t;

    localparam int CODE_W = $bits(fault_code_e);

    // Policy: region membership plus requester identity gives the verdict.
    function automatic verdict_t judge(req_class_e cls, req_kind_e kind,
                                       logic auth, logic in_priv);
        verdict_t v;
        v = '{allow: 1'b0, code: FC_BAD_REQ, tlb_we: 1'b0,
              dma_fwd: 1'b0, fault: 1'b0, err_set: 1'b0};
        unique case (cls)
            CLS_PRIV_CORE: begin
                if (kind == KIND_FILL || kind == KIND_REAL) begin
                    v.allow = 1'b1;
                    v.code  = FC_NONE;
                end
            end
            CLS_UNPRIV_CORE: begin
                if (kind == KIND_FILL) begin
                    v.allow = !in_priv;
                    v.code  = in_priv ? FC_FILL_DENY : FC_NONE;
                end else if (kind == KIND_REAL) begin
                    v.allow = !in_priv;
                    v.code  = in_priv ? FC_REAL_DENY : FC_NONE;
                end
            end
            CLS_DEVICE: begin
                if (kind == KIND_DMA_WR) begin
                    v.allow = !(in_priv && !auth);
                    v.code  = v.allow ? FC_NONE : FC_DMA_BLOCK;
                end else if (kind == KIND_DMA_RD) begin
                    v.allow = 1'b1;
                    v.code  = FC_NONE;
                end
            end
            default: begin
                v.allow = 1'b0;
                v.code  = FC_BAD_REQ;
            end
        endcase
        v.tlb_we  = v.allow && (kind == KIND_FILL);
        v.dma_fwd = v.allow && (cls == CLS_DEVICE);
        v.fault   = !v.allow && (cls != CLS_DEVICE);
        v.err_set = !v.allow && (cls == CLS_DEVICE);
        return v;
    endfunction

endpackage

// File: rtl/psg_bound_reg.sv
module psg_bound_reg
    import pa_split_pkg::*;
#(
    parameter int               ADDR_W    = 40,
    parameter int               PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] BOUND_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_priv,
    input  cfg_op_e           cfg_op,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] bound,
    output logic              err_clr
);
    localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_MASK;
    localparam logic [ADDR_W-1:0] RST_VAL    = BOUND_RST & ALIGN_MASK;

    logic accept;
    logic [ADDR_W-1:0] bound_q;

    assign accept  = cfg_wr && cfg_priv;
    assign err_clr = accept && (cfg_op == CFG_OP_ERRCLR) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q <= RST_VAL;
        end else if (accept && cfg_op == CFG_OP_BOUND) begin
            bound_q <= cfg_wdata & ALIGN_MASK;
        end
    end

    assign bound = bound_q;
endmodule

// File: rtl/psg_region_cmp.sv
module psg_region_cmp #(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] bound,
    output logic              in_priv
);
    // At or above the boundary is the privileged region.
    assign in_priv = (addr >= bound);
endmodule

// File: rtl/psg_err_flag.sv
module psg_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= set | (err_q & ~clr);
        end
    end

    assign err = err_q;
endmodule

// File: rtl/psg_verdict_pipe.sv
module psg_verdict_pipe
    import pa_split_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  verdict_t          in_verdict,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output verdict_t          out_verdict,
    output logic [ADDR_W-1:0] out_addr
);
    localparam verdict_t IDLE = '{allow: 1'b0, code: FC_NONE, tlb_we: 1'b0,
                                  dma_fwd: 1'b0, fault: 1'b0, err_set: 1'b0};

    logic              valid_q;
    verdict_t          verdict_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= IDLE;
            addr_q    <= '0;
        end else begin
            valid_q   <= in_valid;
            verdict_q <= in_valid ? in_verdict : IDLE;
            if (in_valid) begin
                addr_q <= in_addr;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_verdict = verdict_q;
    assign out_addr    = addr_q;
endmodule

// File: rtl/pa_split_guard.sv
module pa_split_guard
    import pa_split_pkg::*;
#(
    parameter int               ADDR_W    = 40,
    parameter int               PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] BOUND_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_i,
    input  logic              cfg_priv_i,
    input  logic              cfg_op_i,
    input  logic [ADDR_W-1:0] cfg_wdata_i,
    output logic [ADDR_W-1:0] bound_o,
    output logic              dma_err_o,
    input  logic              req_valid_i,
    input  logic [1:0]        req_class_i,
    input  logic [1:0]        req_type_i,
    input  logic              req_auth_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              dec_valid_o,
    output logic              dec_allow_o,
    output logic [2:0]        dec_code_o,
    output logic [ADDR_W-1:0] dec_addr_o,
    output logic              tlb_we_o,
    output logic              dma_fwd_o,
    output logic              fault_o
);
    logic [ADDR_W-1:0] bound;
    logic              err_clr;
    logic              in_priv;
    verdict_t          verdict_now;
    verdict_t          verdict_reg;
    logic              err_set;

    psg_bound_reg #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS),
        .BOUND_RST(BOUND_RST)
    ) bound_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr_i),
        .cfg_priv (cfg_priv_i),
        .cfg_op   (cfg_op_e'(cfg_op_i)),
        .cfg_wdata(cfg_wdata_i),
        .bound    (bound),
        .err_clr  (err_clr)
    );

    psg_region_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .addr   (req_addr_i),
        .bound  (bound),
        .in_priv(in_priv)
    );

    always_comb begin
        verdict_now = judge(req_class_e'(req_class_i), req_kind_e'(req_type_i),
                            req_auth_i, in_priv);
    end

    assign err_set = req_valid_i && verdict_now.err_set;

    psg_err_flag err_i (
        .clk(clk),
        .rst(rst),
        .set(err_set),
        .clr(err_clr),
        .err(dma_err_o)
    );

    psg_verdict_pipe #(.ADDR_W(ADDR_W)) pipe_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid_i),
        .in_verdict (verdict_now),
        .in_addr    (req_addr_i),
        .out_valid  (dec_valid_o),
        .out_verdict(verdict_reg),
        .out_addr   (dec_addr_o)
    );

    assign bound_o     = bound;
    assign dec_allow_o = verdict_reg.allow;
    assign dec_code_o  = CODE_W'(verdict_reg.code);
    assign tlb_we_o    = verdict_reg.tlb_we;
    assign dma_fwd_o   = verdict_reg.dma_fwd;
    assign fault_o     = verdict_reg.fault;
endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_i,
    input logic              cfg_priv_i,
    input logic              cfg_op_i,
    input logic [ADDR_W-1:0] cfg_wdata_i,
    input logic [ADDR_W-1:0] bound_o,
    input logic              dma_err_o,
    input logic              req_valid_i,
    input logic [1:0]        req_class_i,
    input logic [1:0]        req_type_i,
    input logic              req_auth_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              dec_valid_o,
    input logic              dec_allow_o,
    input logic [2:0]        dec_code_o,
    input logic              tlb_we_o,
    input logic              dma_fwd_o,
    input logic              fault_o
);
    AST_VERDICT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> dec_valid_o); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !dec_valid_o && !tlb_we_o && !dma_fwd_o && !fault_o); // R5
    AST_UNPRIV_FILL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_class_i == 2'd1 && req_type_i == 2'd0 && req_addr_i >= bound_o
        |=> !tlb_we_o && fault_o && dec_code_o == 3'd1); // R3
    AST_UNPRIV_BELOW_OK: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_class_i == 2'd1 && req_type_i == 2'd0 && req_addr_i < bound_o
        |=> dec_allow_o && tlb_we_o); // R2
    AST_PRIV_CORE_ALLOW: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_class_i == 2'd0 && !req_type_i[1] |=> dec_allow_o && !fault_o); // R4
    AST_DMA_BLOCK: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_class_i == 2'd2 && req_type_i == 2'd2 && !req_auth_i
        && req_addr_i >= bound_o |=> !dma_fwd_o && dma_err_o); // R6
    AST_FAULT_IS_REFUSAL: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> dec_valid_o && !dec_allow_o); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        dma_err_o && !(cfg_wr_i && cfg_priv_i && cfg_op_i && cfg_wdata_i[0]) |=> dma_err_o); // R7
    AST_UNPRIV_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i && !cfg_priv_i |=> $stable(bound_o)); // R8
    AST_RSVD_CLASS: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_class_i == 2'd3 |=> !dec_allow_o && dec_code_o == 3'd4 && fault_o); // R9
endmodule

bind pa_split_guard psg_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_priv_i (cfg_priv_i),
    .cfg_op_i   (cfg_op_i),
    .cfg_wdata_i(cfg_wdata_i),
    .bound_o    (bound_o),
    .dma_err_o  (dma_err_o),
    .req_valid_i(req_valid_i),
    .req_class_i(req_class_i),
    .req_type_i (req_type_i),
    .req_auth_i (req_auth_i),
    .req_addr_i (req_addr_i),
    .dec_valid_o(dec_valid_o),
    .dec_allow_o(dec_allow_o),
    .dec_code_o (dec_code_o),
    .tlb_we_o   (tlb_we_o),
    .dma_fwd_o  (dma_fwd_o),
    .fault_o    (fault_o)
);

// File: tb/pa_split_guard_tb_top.sv
module pa_split_guard_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 20;
    localparam int          PB         = 12;
    localparam logic [19:0] BRST       = 20'h80000;
    localparam logic [19:0] ALIGN      = 20'hFF000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_priv = 1'b0, cfg_op = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] bound_o;
    logic          dma_err_o;
    logic          req_valid = 1'b0;
    logic [1:0]    req_class = '0, req_type = '0;
    logic          req_auth = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          dec_valid_o, dec_allow_o, tlb_we_o, dma_fwd_o, fault_o;
    logic [2:0]    dec_code_o;
    logic [AW-1:0] dec_addr_o;

    pa_split_guard #(.ADDR_W(AW), .PAGE_BITS(PB), .BOUND_RST(BRST)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_i(cfg_wr), .cfg_priv_i(cfg_priv), .cfg_op_i(cfg_op), .cfg_wdata_i(cfg_wdata),
        .bound_o(bound_o), .dma_err_o(dma_err_o),
        .req_valid_i(req_valid), .req_class_i(req_class), .req_type_i(req_type),
        .req_auth_i(req_auth), .req_addr_i(req_addr),
        .dec_valid_o(dec_valid_o), .dec_allow_o(dec_allow_o), .dec_code_o(dec_code_o),
        .dec_addr_o(dec_addr_o), .tlb_we_o(tlb_we_o), .dma_fwd_o(dma_fwd_o), .fault_o(fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Bench model state
    logic [AW-1:0] m_bound;
    logic          m_err;
    logic          p_v;
    logic [2:0]    p_code;
    logic [AW-1:0] p_addr;
    logic          p_tlb, p_fwd, p_fault;
    string         p_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Code values per requirements R2, R3, R4, R6, R9
    function automatic logic [2:0] exp_code(logic [1:0] c, logic [1:0] t, logic a,
                                            logic [AW-1:0] addr, logic [AW-1:0] bnd);
        logic hi;
        hi = (addr >= bnd);
        case (c)
            2'd0: return (t <= 2'd1) ? 3'd0 : 3'd4;
            2'd1: begin
                if (t == 2'd0) return hi ? 3'd1 : 3'd0;
                if (t == 2'd1) return hi ? 3'd2 : 3'd0;
                return 3'd4;
            end
            2'd2: begin
                if (t == 2'd2) return (hi && !a) ? 3'd3 : 3'd0;
                if (t == 2'd3) return 3'd0;
                return 3'd4;
            end
            default: return 3'd4;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] c, logic [1:0] t, logic [AW-1:0] addr,
                                     logic [AW-1:0] bnd, logic bwr);
        if (bwr) return "R10";
        if (c == 2'd3 || (c != 2'd2 && t[1]) || (c == 2'd2 && !t[1])) return "R9";
        if (c == 2'd0) return "R4";
        if (c == 2'd2) return "R6";
        if (addr == bnd || addr + 1 == bnd) return "R2";
        return "R3";
    endfunction

    task automatic check_prev();
        chk(p_v ? p_tag : "R5", "dec_valid", 32'(dec_valid_o), 32'(p_v));
        if (p_v) begin
            chk(p_tag, "allow", 32'(dec_allow_o), 32'(p_code == 3'd0));
            chk(p_tag, "code", 32'(dec_code_o), 32'(p_code));
            chk(p_tag, "addr", 32'(dec_addr_o), 32'(p_addr));
        end
        chk(p_v ? p_tag : "R5", "tlb_we", 32'(tlb_we_o), 32'(p_tlb));
        chk(p_v ? p_tag : "R5", "dma_fwd", 32'(dma_fwd_o), 32'(p_fwd));
        chk(p_v ? p_tag : "R5", "fault", 32'(fault_o), 32'(p_fault));
        chk("R8", "bound", 32'(bound_o), 32'(m_bound));
        chk("R7", "dma_err", 32'(dma_err_o), 32'(m_err));
    endtask

    task automatic step(logic v, logic [1:0] c, logic [1:0] t, logic a, logic [AW-1:0] addr,
                        logic cw, logic cp, logic co, logic [AW-1:0] cd);
        logic [2:0] code;
        logic       clr, set;
        @(negedge clk);
        check_prev();
        req_valid = v; req_class = c; req_type = t; req_auth = a; req_addr = addr;
        cfg_wr = cw; cfg_priv = cp; cfg_op = co; cfg_wdata = cd;
        code    = exp_code(c, t, a, addr, m_bound);
        p_v     = v;
        p_code  = code;
        p_addr  = v ? addr : p_addr;
        p_tlb   = v && code == 3'd0 && t == 2'd0 && c != 2'd2 && c != 2'd3;
        p_fwd   = v && code == 3'd0 && c == 2'd2;
        p_fault = v && code != 3'd0 && c != 2'd2;
        p_tag   = tag_of(c, t, addr, m_bound, cw && cp && !co);
        set     = v && code != 3'd0 && c == 2'd2;
        clr     = cw && cp && co && cd[0];
        m_err   = set | (m_err & ~clr);
        if (cw && cp && !co) m_bound = cd & ALIGN;
    endtask

    task automatic req(logic [1:0] c, logic [1:0] t, logic a, logic [AW-1:0] addr);
        step(1'b1, c, t, a, addr, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic cfg(logic cp, logic co, logic [AW-1:0] cd);
        step(1'b0, 2'd0, 2'd0, 1'b0, '0, 1'b1, cp, co, cd);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bound", 32'(bound_o), 32'(BRST));
        chk("R1", "dma_err", 32'(dma_err_o), 32'd0);
        chk("R1", "dec_valid", 32'(dec_valid_o), 32'd0);
        chk("R1", "flags", {29'd0, tlb_we_o, dma_fwd_o, fault_o}, 32'd0);
        m_bound = BRST; m_err = 1'b0;
        p_v = 0; p_code = 0; p_addr = '0; p_tlb = 0; p_fwd = 0; p_fault = 0; p_tag = "R5";

        // Directed corners
        req(2'd1, 2'd0, 1'b0, 20'h80000);   // R2 at boundary: refused
        req(2'd1, 2'd0, 1'b0, 20'h7FFFF);   // R2 just below: allowed
        req(2'd1, 2'd1, 1'b0, 20'h80000);   // R3 real-mode refused
        req(2'd1, 2'd1, 1'b0, 20'h00010);   // R3 real-mode low allowed
        req(2'd0, 2'd0, 1'b0, 20'hFFFFF);   // R4 privileged fill
        req(2'd0, 2'd1, 1'b0, 20'h80000);   // R4 privileged real
        req(2'd2, 2'd2, 1'b1, 20'h90000);   // R6 authorized write
        req(2'd2, 2'd3, 1'b0, 20'hA0000);   // R6 read
        req(2'd2, 2'd2, 1'b0, 20'h7FFFF);   // R6 low write
        req(2'd2, 2'd2, 1'b0, 20'h80000);   // R6 blocked, sticky set
        cfg(1'b0, 1'b1, 20'h00001);         // R7 unprivileged clear ignored
        cfg(1'b1, 1'b1, 20'h00000);         // R7 bit0 clear: no effect
        step(1'b1, 2'd2, 2'd2, 1'b0, 20'hC0000, 1'b1, 1'b1, 1'b1, 20'h00001); // R7 set wins
        cfg(1'b1, 1'b1, 20'h00001);         // R7 clear
        req(2'd0, 2'd2, 1'b0, 20'h00100);   // R9 core with DMA type
        req(2'd2, 2'd0, 1'b0, 20'h00100);   // R9 device fill
        cfg(1'b1, 1'b1, 20'h00001);
        req(2'd3, 2'd1, 1'b0, 20'h00100);   // R9 reserved class
        cfg(1'b0, 1'b0, 20'h12345);         // R8 unprivileged boundary write ignored
        step(1'b1, 2'd1, 2'd0, 1'b0, 20'h40000, 1'b1, 1'b1, 1'b0, 20'h40ABC); // R10
        req(2'd1, 2'd0, 1'b0, 20'h40000);   // R8 new aligned boundary
        req(2'd1, 2'd0, 1'b0, 20'h3FFFF);
        step(1'b0, 2'd0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] addr;
            logic          cw;
            int            sel;
            sel = int'($urandom_range(0, 3));
            if (sel == 0) addr = AW'($urandom);
            else addr = m_bound + AW'($urandom_range(0, 8)) - AW'(4);
            cw = ($urandom_range(0, 15) == 0);
            step(($urandom_range(0, 7) != 0), 2'($urandom), 2'($urandom), 1'($urandom), addr,
                 cw, 1'($urandom), 1'($urandom), AW'($urandom));
        end
        step(1'b0, 2'd0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
        step(1'b0, 2'd0, 2'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check_prev();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule